// File: doc/BRIEF.md
# Indirect Control Register Port

This block is the register file of a bus-slave network controller. Software reaches it through two 16-bit word ports. A write to the pointer port selects an internal register. The data port then reads or writes whichever register the pointer selects. Two registers can be reached this way. The first is a command and status word. It accepts start, init and stop commands, shows the run and done state, and holds the interrupt flags. The second is a small control register that holds byte-order and bus-control bits.

The DMA engine, the frame path and the loading of the initialization block are not part of this block. They appear here only as single-cycle event inputs, and each event sets its flag in the command and status word. The interrupt output is high while any interrupt source is pending and interrupts are enabled. Reads are combinational from the port offset and the current state. Writes take effect at the next rising clock edge.

Top module: `ctl_csr_port`

## Requirements
- R1: Port offset 1 is the pointer port. A write there stores wdata into the pointer, and a read returns the pointer. Port offset 0 is the data port.
- R2: On the data port, pointer value 0 selects the command and status word and pointer value 3 selects the control register. Any other pointer value reads as 0 on the data port, and a data-port write under such a pointer changes no register.
- R3: Port offsets 2 and 3 read as 0, and writes to them change no register.
- R4: A command-word write with bit 2 (stop) set leaves the word at exactly 16'h0004. Nothing else in that write, and no event in the same cycle, takes effect.
- R5: A command-word write with bit 2 clear and bit 0 (init) set sets bit 0 and bit 8 (init done) and clears bit 2.
- R6: A command-word write with bits 2 and 0 clear and bit 1 (start) set sets bit 1, bit 5 (receiver on) and bit 4 (transmitter on), and clears bit 2. When init and start are written together, only the init action takes place.
- R7: Each event input sets its flag: receive done sets bit 10, transmit done sets bit 9, babble sets bit 14, collision error sets bit 13, missed frame sets bit 12 and memory error sets bit 11. An event takes priority over a clear of the same flag in the same cycle.
- R8: Bit 15 reads as the OR of bits 14 to 11. Bit 7 reads as the OR of bits 14 to 8.
- R9: Bits 14 to 8 are cleared by writing 1 and are kept when 0 is written. Bit 6 (interrupt enable) takes the written value. Writing 1 to bit 3 (transmit demand) sets it, and only a stop clears it. Bits 15, 7, 5 and 4 ignore written values.
- R10: irq_o is high exactly when bit 7 and bit 6 of the command word are both 1. It follows the word in the same cycle.
- R11: In the control register, bits 2 to 0 are read/write and bits 15 to 3 read as 0. A stop does not change this register.
- R12: After reset the command word reads 16'h0004, the pointer reads 0, the control register reads 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed port |
| port_addr | input | PORT_AW | Word offset of the accessed port |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for port_addr, combinational |
| ev_rx_done | input | 1 | Receive-complete event |
| ev_tx_done | input | 1 | Transmit-complete event |
| ev_babble | input | 1 | Transmit timeout event |
| ev_coll_err | input | 1 | Collision error event |
| ev_missed | input | 1 | Missed frame event |
| ev_mem_err | input | 1 | Memory error event |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pointer value changes which register the data port returns, so the error shows on the first data-port read after the pointer write. A wrong flag, or a command path taken in the wrong priority order, shows in rdata during the cycle after the write or event that caused it. A wrong flag also changes the summary bits and irq_o in that same cycle. A behavioural model of the port map is compared with rdata and irq_o on every clock, so a divergence is reported within one cycle of the stimulus that caused it.

// File: rtl/ctl_csr_pkg.sv
package ctl_csr_pkg;

    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    // port offsets
    localparam int PORT_DATA = 0;
    localparam int PORT_PTR  = 1;

    // register indices behind the pointer
    localparam int REG_CMD = 0;
    localparam int REG_AUX = 3;

    // command/status bit positions
    localparam int B_ERR  = 15;
    localparam int B_BABL = 14;
    localparam int B_COLL = 13;
    localparam int B_MISS = 12;
    localparam int B_MERR = 11;
    localparam int B_RINT = 10;
    localparam int B_TINT = 9;
    localparam int B_IDON = 8;
    localparam int B_INTR = 7;
    localparam int B_INEA = 6;
    localparam int B_RXON = 5;
    localparam int B_TXON = 4;
    localparam int B_TDMD = 3;
    localparam int B_STOP = 2;
    localparam int B_STRT = 1;
    localparam int B_INIT = 0;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CMD  = 2'd1,
        SRC_AUX  = 2'd2,
        SRC_PTR  = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic babble;
        logic coll;
        logic miss;
        logic memerr;
        logic rx;
        logic tx;
    } evt_t;

    typedef struct packed {
        logic babble;
        logic coll;
        logic miss;
        logic memerr;
        logic rint;
        logic tint;
        logic idon;
        logic inea;
        logic rxon;
        logic txon;
        logic tdmd;
        logic stop;
        logic strt;
        logic init;
    } cmd_st_t;

    localparam cmd_st_t CMD_RESET = '{stop: 1'b1, default: 1'b0};

    function automatic logic err_summary(input cmd_st_t s);
        return s.babble | s.coll | s.miss | s.memerr;
    endfunction

    function automatic logic int_summary(input cmd_st_t s);
        return err_summary(s) | s.rint | s.tint | s.idon;
    endfunction

    function automatic word_t pack_cmd(input cmd_st_t s);
        word_t w;
        w         = '0;
        w[B_ERR]  = err_summary(s);
        w[B_BABL] = s.babble;
        w[B_COLL] = s.coll;
        w[B_MISS] = s.miss;
        w[B_MERR] = s.memerr;
        w[B_RINT] = s.rint;
        w[B_TINT] = s.tint;
        w[B_IDON] = s.idon;
        w[B_INTR] = int_summary(s);
        w[B_INEA] = s.inea;
        w[B_RXON] = s.rxon;
        w[B_TXON] = s.txon;
        w[B_TDMD] = s.tdmd;
        w[B_STOP] = s.stop;
        w[B_STRT] = s.strt;
        w[B_INIT] = s.init;
        return w;
    endfunction

endpackage

// File: rtl/ctl_csr_decode.sv
module ctl_csr_decode
    import ctl_csr_pkg::*;
#(
    parameter int PORT_AW = 2,
    parameter int PTR_W   = 16
) (
    input  logic               wr_en,
    input  logic [PORT_AW-1:0] port_addr,
    input  logic [PTR_W-1:0]   ptr,
    output logic               cmd_wr,
    output logic               aux_wr,
    output logic               ptr_wr,
    output rd_src_e            src
);
    localparam logic [PORT_AW-1:0] DATA_OFS = PORT_AW'(PORT_DATA);
    localparam logic [PORT_AW-1:0] PTR_OFS  = PORT_AW'(PORT_PTR);
    localparam logic [PTR_W-1:0]   CMD_IDX  = PTR_W'(REG_CMD);
    localparam logic [PTR_W-1:0]   AUX_IDX  = PTR_W'(REG_AUX);

    logic on_data, on_ptr, sel_cmd, sel_aux;

    always_comb begin
        on_data = (port_addr == DATA_OFS);
        on_ptr  = (port_addr == PTR_OFS);
        sel_cmd = (ptr == CMD_IDX);
        sel_aux = (ptr == AUX_IDX);

        cmd_wr = wr_en && on_data && sel_cmd;
        aux_wr = wr_en && on_data && sel_aux;
        ptr_wr = wr_en && on_ptr;

        if (on_ptr)                src = SRC_PTR;
        else if (on_data && sel_cmd) src = SRC_CMD;
        else if (on_data && sel_aux) src = SRC_AUX;
        else                       src = SRC_NONE;
    end
endmodule

// File: rtl/ctl_csr_ptr.sv
module ctl_csr_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] din,
    output logic [PTR_W-1:0] ptr_q
);
    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= '0;
        else if (load) ptr_q <= din;
    end
endmodule

// File: rtl/ctl_csr_aux.sv
module ctl_csr_aux #(
    parameter int AUX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AUX_W-1:0] din,
    output logic [AUX_W-1:0] aux_q
);
    // bit 2 byte swap, bit 1 address-latch control, bit 0 byte control
    for (genvar i = 0; i < AUX_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)     aux_q[i] <= 1'b0;
            else if (wr) aux_q[i] <= din[i];
        end
    end
endmodule

// File: rtl/ctl_csr_cmd.sv
module ctl_csr_cmd
    import ctl_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  word_t wdata,
    input  evt_t  evt,
    output word_t word_o,
    output logic  irq_o
);
    cmd_st_t st_q, st_d;
    logic    stop_wr;
    logic    unused_ro;

    // written values of read-only bits have no effect
    assign unused_ro = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};

    always_comb begin
        st_d    = st_q;
        stop_wr = wr && wdata[B_STOP];
        if (stop_wr) begin
            st_d = CMD_RESET;
        end else begin
            if (wr) begin
                if (wdata[B_BABL]) st_d.babble = 1'b0;
                if (wdata[B_COLL]) st_d.coll   = 1'b0;
                if (wdata[B_MISS]) st_d.miss   = 1'b0;
                if (wdata[B_MERR]) st_d.memerr = 1'b0;
                if (wdata[B_RINT]) st_d.rint   = 1'b0;
                if (wdata[B_TINT]) st_d.tint   = 1'b0;
                if (wdata[B_IDON]) st_d.idon   = 1'b0;
                st_d.inea = wdata[B_INEA];
                if (wdata[B_TDMD]) st_d.tdmd = 1'b1;
                if (wdata[B_INIT]) begin
                    st_d.init = 1'b1;
                    st_d.idon = 1'b1;
                    st_d.stop = 1'b0;
                end else if (wdata[B_STRT]) begin
                    st_d.strt = 1'b1;
                    st_d.rxon = 1'b1;
                    st_d.txon = 1'b1;
                    st_d.stop = 1'b0;
                end
            end
            st_d.babble = st_d.babble | evt.babble;
            st_d.coll   = st_d.coll   | evt.coll;
            st_d.miss   = st_d.miss   | evt.miss;
            st_d.memerr = st_d.memerr | evt.memerr;
            st_d.rint   = st_d.rint   | evt.rx;
            st_d.tint   = st_d.tint   | evt.tx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CMD_RESET;
        else     st_q <= st_d;
    end

    assign word_o = pack_cmd(st_q);
    assign irq_o  = int_summary(st_q) & st_q.inea;
endmodule

// File: rtl/ctl_csr_port.sv
module ctl_csr_port
    import ctl_csr_pkg::*;
#(
    parameter int PORT_AW = 2,
    parameter int PTR_W   = 16,
    parameter int AUX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PORT_AW-1:0] port_addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    input  logic               ev_rx_done,
    input  logic               ev_tx_done,
    input  logic               ev_babble,
    input  logic               ev_coll_err,
    input  logic               ev_missed,
    input  logic               ev_mem_err,
    output logic               irq_o
);
    logic             cmd_wr, aux_wr, ptr_wr;
    rd_src_e          src;
    logic [PTR_W-1:0] ptr_q;
    logic [AUX_W-1:0] aux_q;
    word_t            cmd_word;
    evt_t             evt;

    assign evt = '{babble: ev_babble, coll: ev_coll_err, miss: ev_missed,
                   memerr: ev_mem_err, rx: ev_rx_done, tx: ev_tx_done};

    ctl_csr_decode #(.PORT_AW(PORT_AW), .PTR_W(PTR_W)) u_dec (
        .wr_en(wr_en), .port_addr(port_addr), .ptr(ptr_q),
        .cmd_wr(cmd_wr), .aux_wr(aux_wr), .ptr_wr(ptr_wr), .src(src)
    );

    ctl_csr_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst(rst), .load(ptr_wr),
        .din(wdata[PTR_W-1:0]), .ptr_q(ptr_q)
    );

    ctl_csr_aux #(.AUX_W(AUX_W)) u_aux (
        .clk(clk), .rst(rst), .wr(aux_wr),
        .din(wdata[AUX_W-1:0]), .aux_q(aux_q)
    );

    ctl_csr_cmd u_cmd (
        .clk(clk), .rst(rst), .wr(cmd_wr), .wdata(wdata), .evt(evt),
        .word_o(cmd_word), .irq_o(irq_o)
    );

    always_comb begin
        unique case (src)
            SRC_CMD: rdata = cmd_word;
            SRC_AUX: rdata = word_t'(aux_q);
            SRC_PTR: rdata = word_t'(ptr_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctl_csr_chk.sv
module ctl_csr_chk #(
    parameter int PORT_AW = 2,
    parameter int PTR_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [PORT_AW-1:0] port_addr,
    input logic [15:0]        wdata,
    input logic               ev_rx_done,
    input logic [PTR_W-1:0]   ptr_q,
    input logic [15:0]        cmd_word,
    input logic               irq_o
);
    logic cmd_write;
    assign cmd_write = wr_en && (port_addr == PORT_AW'(0)) && (ptr_q == '0);

    // R1: pointer port loads the written value
    p_ptr_load_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == PORT_AW'(1)) |=> ptr_q == $past(wdata[PTR_W-1:0]));

    // R3: undefined port offsets leave the pointer alone
    p_undef_port_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr > PORT_AW'(1)) |=> $stable(ptr_q));

    // R4: stop leaves only the stop bit
    p_stop_only_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_write && wdata[2]) |=> cmd_word == 16'h0004);

    // R5: init sets init and init-done, clears stop
    p_init_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_write && !wdata[2] && wdata[0]) |=> (cmd_word[0] && cmd_word[8] && !cmd_word[2]));

    // R6: start sets start, receiver on, transmitter on
    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_write && !wdata[2] && !wdata[0] && wdata[1])
        |=> (cmd_word[1] && cmd_word[5] && cmd_word[4] && !cmd_word[2]));

    // R7: receive event wins over a same-cycle clear
    p_rx_evt_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_done && !(cmd_write && wdata[2])) |=> cmd_word[10]);

    // R10: interrupt only with enable and a pending summary
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cmd_word[6] && cmd_word[7]));
endmodule

bind ctl_csr_port ctl_csr_chk #(.PORT_AW(PORT_AW), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .port_addr(port_addr), .wdata(wdata),
    .ev_rx_done(ev_rx_done), .ptr_q(ptr_q), .cmd_word(cmd_word), .irq_o(irq_o)
);

// File: tb/tb_ctl_csr_port.sv
module tb_ctl_csr_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  port_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ev_rx_done = 0, ev_tx_done = 0, ev_babble = 0;
    logic        ev_coll_err = 0, ev_missed = 0, ev_mem_err = 0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ctl_csr_port dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .port_addr(port_addr),
        .wdata(wdata), .rdata(rdata),
        .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_babble(ev_babble),
        .ev_coll_err(ev_coll_err), .ev_missed(ev_missed), .ev_mem_err(ev_mem_err),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [15:0] m_word = 16'h0004;
    logic [15:0] m_ptr  = 16'h0000;
    logic [15:0] m_aux  = 16'h0000;

    function automatic logic [15:0] m_read(input logic [1:0] a);
        if (a == 2'd1) return m_ptr;
        if (a == 2'd0) begin
            if (m_ptr == 16'd0) return m_word;
            if (m_ptr == 16'd3) return m_aux;
        end
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        logic        halt;
        logic [15:0] evm;
        if (rst) begin
            m_word = 16'h0004;
            m_ptr  = 16'h0000;
            m_aux  = 16'h0000;
        end else begin
            halt = wr_en && port_addr == 2'd0 && m_ptr == 16'd0 && wdata[2];
            evm  = {1'b0, ev_babble, ev_coll_err, ev_missed, ev_mem_err,
                    ev_rx_done, ev_tx_done, 9'd0};
            if (wr_en && port_addr == 2'd1) begin
                m_ptr = wdata;
            end else if (wr_en && port_addr == 2'd0 && m_ptr == 16'd3) begin
                m_aux = wdata & 16'h0007;
            end else if (wr_en && port_addr == 2'd0 && m_ptr == 16'd0) begin
                if (halt) m_word = 16'h0004;
                else begin
                    m_word    = m_word & ~(wdata & 16'h7F00);
                    m_word[6] = wdata[6];
                    if (wdata[3]) m_word[3] = 1'b1;
                    if (wdata[0])      m_word = (m_word | 16'h0101) & ~16'h0004;
                    else if (wdata[1]) m_word = (m_word | 16'h0032) & ~16'h0004;
                end
            end
            if (!halt) m_word = m_word | evm;
            m_word[15] = |m_word[14:11];
            m_word[7]  = |m_word[14:8];
        end
    end

    // compare against the model on every clock
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            checks++;
            if (rdata !== m_read(port_addr) || irq_o !== (m_word[7] & m_word[6])) begin
                errors++;
                $display("FAIL R2 model compare: rdata=%h irq=%b expected rdata=%h irq=%b",
                         rdata, irq_o, m_read(port_addr), m_word[7] & m_word[6]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic we, input logic [1:0] a, input logic [15:0] d,
                         input logic [5:0] ev);
        @(negedge clk);
        wr_en = we; port_addr = a; wdata = d;
        {ev_babble, ev_coll_err, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done} = ev;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        drive(1'b1, a, d, 6'd0);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        drive(1'b0, a, 16'h0000, 6'd0);
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s port %0d: actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq: actual=%b expected=%b", tag, irq_o, exp);
        end
    endtask

    // event mask order: babble, coll, miss, memerr, rx, tx
    localparam logic [5:0] EV_BABL = 6'b100000;
    localparam logic [5:0] EV_COLL = 6'b010000;
    localparam logic [5:0] EV_MISS = 6'b001000;
    localparam logic [5:0] EV_MERR = 6'b000100;
    localparam logic [5:0] EV_RX   = 6'b000010;
    localparam logic [5:0] EV_TX   = 6'b000001;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk_rd(2'd0, 16'h0004, "R12 reset word");
        chk_irq(1'b0, "R12 reset");
        chk_rd(2'd1, 16'h0000, "R12 reset pointer");

        // R1 / R11 pointer and control register
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'hFFFD);
        chk_rd(2'd0, 16'h0005, "R11 control register");
        chk_rd(2'd1, 16'h0003, "R1 pointer readback");
        wr(2'd1, 16'h0000);

        // R6 start
        wr(2'd0, 16'h0002);
        chk_rd(2'd0, 16'h0032, "R6 start");

        // R5 init with enable, R8 summary, R10 irq
        wr(2'd0, 16'h0041);
        chk_rd(2'd0, 16'h01F3, "R5 init");
        chk_irq(1'b1, "R10 enabled done");

        // R9 clear init-done
        wr(2'd0, 16'h0140);
        chk_rd(2'd0, 16'h0073, "R9 w1c init done");
        chk_irq(1'b0, "R10 nothing pending");

        // R7 / R8 events
        drive(1'b0, 2'd0, 16'h0000, EV_RX | EV_BABL);
        chk_rd(2'd0, 16'hC4F3, "R8 error summary");
        chk_irq(1'b1, "R10 rx pending");

        // R7 event beats same-cycle clear
        drive(1'b1, 2'd0, 16'h4440, EV_RX);
        chk_rd(2'd0, 16'h04F3, "R7 set wins over clear");

        // R9 read-only bits
        wr(2'd0, 16'h80F0);
        chk_rd(2'd0, 16'h04F3, "R9 read-only bits");

        // R9 transmit demand
        wr(2'd0, 16'h0448);
        chk_rd(2'd0, 16'h007B, "R9 transmit demand");

        // R3 undefined port offsets
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        chk_rd(2'd2, 16'h0000, "R3 offset 2 read");
        chk_rd(2'd3, 16'h0000, "R3 offset 3 read");
        chk_rd(2'd0, 16'h007B, "R3 word untouched");
        chk_rd(2'd1, 16'h0000, "R3 pointer untouched");

        // R2 undefined pointer value
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'hFFFF);
        chk_rd(2'd0, 16'h0000, "R2 unmapped index read");
        wr(2'd1, 16'h0000);
        chk_rd(2'd0, 16'h007B, "R2 word after unmapped write");
        wr(2'd1, 16'h0003);
        chk_rd(2'd0, 16'h0005, "R2 control after unmapped write");
        wr(2'd1, 16'h0000);

        // R4 stop with everything else
        drive(1'b1, 2'd0, 16'h0045, 6'b111111);
        chk_rd(2'd0, 16'h0004, "R4 stop only");
        chk_irq(1'b0, "R4 stop irq");
        wr(2'd1, 16'h0003);
        chk_rd(2'd0, 16'h0005, "R11 control kept over stop");
        wr(2'd1, 16'h0000);

        // R6 init and start together: init only
        wr(2'd0, 16'h0003);
        chk_rd(2'd0, 16'h0181, "R6 init has priority");

        // R7 each source
        wr(2'd0, 16'h7F00);
        drive(1'b0, 2'd0, 16'h0000, EV_TX);
        chk_rd(2'd0, 16'h0281, "R7 transmit event");
        drive(1'b0, 2'd0, 16'h0000, EV_COLL);
        chk_rd(2'd0, 16'hA281, "R7 collision event");
        drive(1'b0, 2'd0, 16'h0000, EV_MISS);
        chk_rd(2'd0, 16'hB281, "R7 missed event");
        drive(1'b0, 2'd0, 16'h0000, EV_MERR);
        chk_rd(2'd0, 16'hBA81, "R7 memory error event");
        wr(2'd0, 16'h0040);
        chk_rd(2'd0, 16'hBAC1, "R10 enable");
        chk_irq(1'b1, "R10 enable irq");
        wr(2'd0, 16'h7F40);
        chk_rd(2'd0, 16'h0041, "R9 clear all");
        chk_irq(1'b0, "R10 cleared");

        // mixed traffic, checked by the model every clock
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [1:0]  a;
            logic [15:0] d;
            r = $urandom_range(0, 7);
            a = (r < 4) ? 2'd0 : (r < 6) ? 2'd1 : r[1:0];
            d = $urandom();
            if (a == 2'd1) d = ($urandom_range(0, 3) == 0) ? d : (($urandom_range(0, 1) == 0) ? 16'd0 : 16'd3);
            if (a == 2'd0 && $urandom_range(0, 3) != 0) d[2] = 1'b0;
            drive($urandom_range(0, 1) == 1, a,
                  d, ($urandom_range(0, 2) == 0) ? 6'($urandom()) : 6'd0);
        end
        drive(1'b0, 2'd0, 16'h0000, 6'd0);
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule